// File: doc/BRIEF.md
# Tri-State PWM Gate-Drive Sequencer

This block sits between a decoded PWM command and the gate drivers of one synchronous buck phase. Each clock it reads a two-bit level code (low, high or mid-band) and decides which of the two switches may conduct. It never lets both switches conduct together. Every turn-on waits for the opposite gate's discharge feedback and then for a fixed settle count. A mid-band code that lasts for the full hold-off interval parks both gates off.

Two optional behaviours reduce loss at light load. The first is diode emulation, selected by an active-low enable. When it is on, the low-side gate opens a blanking window after it turns on. After that window, a zero-cross indication turns the low-side gate off, and it stays off until the next high command. The second is the mid-band hold-off, which also turns the low-side gate off whatever the inductor current is.

A disable input and a supply-good bit from an external undervoltage monitor both override the command and force both gates off.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: When the code reads high (2'b01), the low gate turns off at the next edge and the state enters HS_WAIT. The high gate turns on only after `ls_off_fb` has read 1 on HS_DLY_CYC+1 consecutive edges. With the default of 1, the high gate is on in the third cycle after the code change.
- R2: When the code reads low (2'b00), the high gate turns off at the next edge and the state enters LS_WAIT. The low gate turns on only after `hs_off_fb` has read 1 on LS_DLY_CYC+1 consecutive edges.
- R3: `hs_gate` and `ls_gate` are never 1 in the same cycle. While the opposite feedback bit reads 0, a waiting gate stays off indefinitely.
- R4: Codes 2'b10 and 2'b11 are the mid band. On the HOLD_CYC-th consecutive edge that samples the mid band, both gates go off. Default HOLD_CYC is 13, about 130 ns at 100 MHz. Before that edge, the present state is held.
- R5: When a valid high or low code appears before the hold-off expires, normal switching resumes. Each new entry into the mid band restarts the hold-off count from zero.
- R6: If `dis_n` is sampled at anything other than logic 1, both gates are off from the next edge on, and they stay off for as long as it remains so.
- R7: If `supply_ok` is sampled at 0, both gates are off from the next edge on, and they stay off for as long as it remains so.
- R8: With `de_n`=0 and a low code, the low gate turns on in state LS_BLANK for exactly BLANK_CYC cycles (default 4), and `zc_det` is ignored during that window. The state then moves to LS_ON. There, `zc_det`=1 turns the low gate off at the next edge.
- R9: After a zero-cross turn-off, the low gate stays off while the code stays low. It can turn on again only after the code has read high.
- R10: With `de_n`=1, `zc_det` has no effect, and the low gate stays on for the whole low period.
- R11: With `de_n`=0 and `zc_det`=0, a mid band that lasts past the hold-off still turns the low gate off.
- R12: A synchronous `rst_n`=0 forces state OFF with both gates off. `state_code` is one-hot, with the bit positions OFF=0, HS_WAIT=1, HS_ON=2, LS_WAIT=3, LS_ON=4 and LS_BLANK=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_code | input | 2 | Level code: 00 low, 01 high, 1x mid band |
| dis_n | input | 1 | Active-low disable; only logic 1 allows switching |
| de_n | input | 1 | Active-low diode-emulation enable |
| zc_det | input | 1 | Zero-cross comparator: 1 when inductor current has reached zero |
| hs_off_fb | input | 1 | 1 when the high gate has discharged |
| ls_off_fb | input | 1 | 1 when the low gate has discharged |
| supply_ok | input | 1 | Supply-good from the undervoltage monitor |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| state_code | output | 6 | One-hot sequencer state for debug |

## Verification
The bound checker watches, on every cycle, the properties that hold at all times:
- the two gates are mutually exclusive;
- each gate's rising edge is preceded by discharge feedback from the other gate;
- the one-cycle forced-off response to disable and to loss of supply;
- the one-hot state code.

Some behaviours depend on a history of inputs, and only the directed scenarios show them:
- the exact turn-on cycle after the settle count;
- the length of the blanking window;
- the hold-off expiry and its restart on re-entry;
- the latched zero-cross turn-off;
- the masking of `zc_det` when diode emulation is off.

// File: rtl/pwm_gate_pkg.sv
// Shared types for the PWM gate-drive sequencer.
// Assumes the level code is already decoded from the analog thresholds.
package pwm_gate_pkg;

    typedef enum logic [1:0] {
        PWM_LOW  = 2'b00,
        PWM_HIGH = 2'b01,
        PWM_MIDA = 2'b10,
        PWM_MIDB = 2'b11
    } pwm_code_e;

    // One-hot sequencer states; the bit positions are visible on state_code.
    typedef enum logic [5:0] {
        ST_OFF      = 6'b000001,
        ST_HS_WAIT  = 6'b000010,
        ST_HS_ON    = 6'b000100,
        ST_LS_WAIT  = 6'b001000,
        ST_LS_ON    = 6'b010000,
        ST_LS_BLANK = 6'b100000
    } gate_state_e;

endpackage

// File: rtl/cycle_gate_timer.sv
// Counts consecutive cycles in which both arm and ready are high.
// done rises once DLY such cycles have already been counted, so a state
// that waits on done lasts DLY+1 cycles once ready holds.
// Assumes arm drops when the waiting state is left.
module cycle_gate_timer #(
    parameter int DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ready,
    output logic done
);
    localparam int W = $clog2(DLY + 2);

    logic [W-1:0] cnt_q;

    assign done = arm && ready && (cnt_q == W'(DLY));

    // Count qualified cycles, clearing whenever the wait is broken.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !ready) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tristate_holdoff.sv
// Measures how long the PWM code has stayed in the mid band.
// expire is high on the HOLD-th consecutive mid-band sample.
// The count returns to zero on any valid level.
module tristate_holdoff #(
    parameter int HOLD = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_mid,
    output logic expire
);
    localparam int W    = $clog2(HOLD + 1);
    localparam int LAST = HOLD - 1;

    logic [W-1:0] run_q;

    assign expire = in_mid && (run_q == W'(LAST));

    // Track consecutive mid-band samples, saturating at HOLD-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_mid) begin
            run_q <= '0;
        end else if (run_q != W'(LAST)) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_gate_ctrl.sv
// Break-before-make sequencer for one buck phase.
// It combines the mid-band hold-off, the gate-feedback settle delays and
// zero-cross diode emulation behind one interlocked gate pair.
// Assumes all inputs are already synchronised to clk.
module pwm_gate_ctrl
    import pwm_gate_pkg::*;
#(
    parameter int HOLD_CYC   = 13,
    parameter int HS_DLY_CYC = 1,
    parameter int LS_DLY_CYC = 1,
    parameter int BLANK_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_code,
    input  logic       dis_n,
    input  logic       de_n,
    input  logic       zc_det,
    input  logic       hs_off_fb,
    input  logic       ls_off_fb,
    input  logic       supply_ok,
    output logic       hs_gate,
    output logic       ls_gate,
    output logic [5:0] state_code
);
    localparam int BLANK_LAST = BLANK_CYC - 1;

    gate_state_e st_q, st_nxt;
    logic        zc_lat_q, zc_lat_nxt;
    logic        run_ok, pwm_hi, pwm_lo, pwm_mid;
    logic        hs_go, ls_go, blank_done, hold_expire;

    // Only a solid logic one on the disable pin allows switching.
    assign run_ok  = (dis_n === 1'b1) && supply_ok;
    assign pwm_hi  = (pwm_code == PWM_HIGH);
    assign pwm_lo  = (pwm_code == PWM_LOW);
    assign pwm_mid = pwm_code[1];

    cycle_gate_timer #(.DLY(HS_DLY_CYC)) u_hs_settle (
        .clk(clk), .rst_n(rst_n),
        .arm(st_q == ST_HS_WAIT), .ready(ls_off_fb), .done(hs_go)
    );

    cycle_gate_timer #(.DLY(LS_DLY_CYC)) u_ls_settle (
        .clk(clk), .rst_n(rst_n),
        .arm(st_q == ST_LS_WAIT), .ready(hs_off_fb), .done(ls_go)
    );

    cycle_gate_timer #(.DLY(BLANK_LAST)) u_blank (
        .clk(clk), .rst_n(rst_n),
        .arm(st_q == ST_LS_BLANK), .ready(1'b1), .done(blank_done)
    );

    tristate_holdoff #(.HOLD(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_mid(pwm_mid), .expire(hold_expire)
    );

    // Choose the next gate state from the command, the overrides and the timers.
    always_comb begin
        st_nxt     = st_q;
        zc_lat_nxt = zc_lat_q;
        if (!run_ok) begin
            st_nxt = ST_OFF;
        end else if (pwm_hi) begin
            zc_lat_nxt = 1'b0;
            if (st_q == ST_HS_WAIT) begin
                if (hs_go) st_nxt = ST_HS_ON;
            end else if (st_q != ST_HS_ON) begin
                st_nxt = ST_HS_WAIT;
            end
        end else if (pwm_lo) begin
            unique case (st_q)
                ST_LS_WAIT: begin
                    if (ls_go) st_nxt = de_n ? ST_LS_ON : ST_LS_BLANK;
                end
                ST_LS_BLANK: begin
                    if (blank_done) st_nxt = ST_LS_ON;
                end
                ST_LS_ON: begin
                    if (!de_n && zc_det) begin
                        st_nxt     = ST_OFF;
                        zc_lat_nxt = 1'b1;
                    end
                end
                default: begin
                    st_nxt = zc_lat_q ? ST_OFF : ST_LS_WAIT;
                end
            endcase
        end else if (hold_expire) begin
            st_nxt = ST_OFF;
        end
    end

    // Register the sequencer state and the zero-cross latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_OFF;
            zc_lat_q <= 1'b0;
        end else begin
            st_q     <= st_nxt;
            zc_lat_q <= zc_lat_nxt;
        end
    end

    // Decode the gate enables from the one-hot state.
    always_comb begin
        hs_gate    = (st_q == ST_HS_ON);
        ls_gate    = (st_q == ST_LS_ON) || (st_q == ST_LS_BLANK);
        state_code = st_q;
    end
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
// Cycle-by-cycle safety properties for pwm_gate_ctrl, attached by bind.
// Assumes a synchronous active-low reset.
module pwm_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dis_n,
    input logic       supply_ok,
    input logic       hs_off_fb,
    input logic       ls_off_fb,
    input logic       hs_gate,
    input logic       ls_gate,
    input logic [5:0] state_code
);
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    assert_hs_rise_after_ls_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_off_fb) && !$past(ls_gate)));

    assert_ls_rise_after_hs_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_off_fb) && !$past(hs_gate)));

    assert_disable_forces_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_n |=> (!hs_gate && !ls_gate));

    assert_supply_loss_forces_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_gate && !ls_gate));

    assert_state_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_code) == 1);
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dis_n(dis_n), .supply_ok(supply_ok),
    .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .state_code(state_code)
);

// File: tb/tb_pwm_gate_ctrl.sv
// Directed bench for pwm_gate_ctrl with default parameters.
module tb_pwm_gate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pwm_code;
    logic       dis_n, de_n, zc_det, hs_off_fb, ls_off_fb, supply_ok;
    logic       hs_gate, ls_gate;
    logic [5:0] state_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    localparam logic [1:0] LO = 2'b00, HI = 2'b01, MID = 2'b10, MID2 = 2'b11;
    localparam logic [5:0] S_OFF = 6'b000001, S_HSW = 6'b000010, S_HSON = 6'b000100,
                           S_LSW = 6'b001000, S_LSON = 6'b010000, S_BLK = 6'b100000;

    pwm_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwm_code(pwm_code), .dis_n(dis_n), .de_n(de_n),
        .zc_det(zc_det), .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
        .supply_ok(supply_ok), .hs_gate(hs_gate), .ls_gate(ls_gate),
        .state_code(state_code)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_gates(input string tag, input logic eh, input logic el);
        n_chk++;
        if (hs_gate !== eh || ls_gate !== el) begin
            n_fail++;
            $display("FAIL %s gates hs/ls=%b%b expected %b%b", tag, hs_gate, ls_gate, eh, el);
        end
    endtask

    task automatic chk_state(input string tag, input logic [5:0] es);
        n_chk++;
        if (state_code !== es) begin
            n_fail++;
            $display("FAIL %s state=%b expected %b", tag, state_code, es);
        end
    endtask

    task automatic go_hs_on();
        pwm_code = HI; tick(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwm_code = LO; dis_n = 1'b1; de_n = 1'b1; zc_det = 1'b0;
        hs_off_fb = 1'b1; ls_off_fb = 1'b1; supply_ok = 1'b1;
        tick(3);
        chk_state("R12 reset", S_OFF); chk_gates("R12 reset", 1'b0, 1'b0);
        pwm_code = MID; rst_n = 1'b1; tick(2);
        chk_state("R12 idle after reset", S_OFF);
    endtask

    task automatic t_high();
        pwm_code = HI; tick(1);
        chk_state("R1 enter HS_WAIT", S_HSW); chk_gates("R1 wait", 1'b0, 1'b0);
        tick(1); chk_gates("R1 settle", 1'b0, 1'b0);
        tick(1); chk_state("R1 HS_ON", S_HSON); chk_gates("R1 on", 1'b1, 1'b0);
    endtask

    task automatic t_low_no_de();
        de_n = 1'b1; zc_det = 1'b1; pwm_code = LO; tick(1);
        chk_state("R2 enter LS_WAIT", S_LSW); chk_gates("R2 hs off first", 1'b0, 1'b0);
        tick(2); chk_state("R2 LS_ON", S_LSON); chk_gates("R2 on", 1'b0, 1'b1);
        tick(8); chk_gates("R10 zc ignored", 1'b0, 1'b1);
        zc_det = 1'b0;
    endtask

    task automatic t_feedback();
        ls_off_fb = 1'b0; pwm_code = HI; tick(1);
        chk_gates("R3 ls off on high", 1'b0, 0);
        tick(5); chk_gates("R3 hs waits for ls fb", 1'b0, 1'b0);
        ls_off_fb = 1'b1; tick(1); chk_gates("R3 settle after fb", 1'b0, 1'b0);
        tick(1); chk_gates("R3 hs on after fb", 1'b1, 1'b0);
        hs_off_fb = 1'b0; pwm_code = LO; tick(4);
        chk_gates("R3 ls waits for hs fb", 1'b0, 1'b0);
        hs_off_fb = 1'b1; tick(2); chk_gates("R3 ls on after fb", 1'b0, 1'b1);
    endtask

    task automatic t_de_blank();
        go_hs_on();
        de_n = 1'b0; zc_det = 1'b1; pwm_code = LO; tick(3);
        chk_state("R8 LS_BLANK", S_BLK); chk_gates("R8 blank on", 1'b0, 1'b1);
        tick(3); chk_state("R8 blank masks zc", S_BLK);
        tick(1); chk_state("R8 LS_ON after blank", S_LSON);
        tick(1); chk_gates("R8 zc turns ls off", 1'b0, 1'b0);
        zc_det = 1'b0; tick(6);
        chk_gates("R9 stays off while low", 1'b0, 1'b0); chk_state("R9 OFF", S_OFF);
        pwm_code = HI; tick(3); chk_gates("R9 high rearms", 1'b1, 1'b0);
    endtask

    task automatic t_zc_late();
        de_n = 1'b0; zc_det = 1'b0; pwm_code = LO; tick(7);
        chk_state("R8 LS_ON no zc", S_LSON);
        tick(3); chk_gates("R8 ls held without zc", 1'b0, 1'b1);
        zc_det = 1'b1; tick(1); chk_gates("R8 late zc off", 1'b0, 1'b0);
        zc_det = 1'b0;
    endtask

    task automatic t_hold();
        go_hs_on();
        pwm_code = MID2; tick(12); chk_gates("R4 before hold-off", 1'b1, 1'b0);
        tick(1); chk_gates("R4 hold-off off", 1'b0, 1'b0); chk_state("R4 OFF", S_OFF);
    endtask

    task automatic t_hold_restart();
        de_n = 1'b1; pwm_code = LO; tick(3); chk_gates("R5 ls on", 1'b0, 1'b1);
        pwm_code = MID; tick(10); pwm_code = LO; tick(1);
        chk_gates("R5 resume low", 1'b0, 1'b1);
        pwm_code = MID; tick(10); chk_gates("R5 counter restarted", 1'b0, 1'b1);
        tick(2); chk_gates("R5 still on at 12", 1'b0, 1'b1);
        tick(1); chk_gates("R5 off at 13", 1'b0, 1'b0);
    endtask

    task automatic t_de_mid();
        de_n = 1'b0; zc_det = 1'b0; pwm_code = LO; tick(7);
        chk_state("R11 LS_ON", S_LSON);
        pwm_code = MID; tick(12); chk_gates("R11 before expiry", 1'b0, 1'b1);
        tick(1); chk_gates("R11 off without zc", 1'b0, 1'b0);
        de_n = 1'b1;
    endtask

    task automatic t_disable();
        go_hs_on(); chk_gates("R6 pre", 1'b1, 1'b0);
        dis_n = 1'b0; tick(1); chk_gates("R6 forced off", 1'b0, 1'b0);
        pwm_code = LO; tick(4); chk_gates("R6 held off", 1'b0, 1'b0);
        dis_n = 1'b1; tick(3); chk_gates("R6 release", 1'b0, 1'b1);
    endtask

    task automatic t_supply();
        supply_ok = 1'b0; tick(1); chk_gates("R7 clamp", 1'b0, 1'b0);
        pwm_code = HI; tick(4); chk_gates("R7 held", 1'b0, 1'b0);
        supply_ok = 1'b1; tick(3); chk_gates("R7 restore", 1'b1, 1'b0);
    endtask

    task automatic t_mid_reset();
        rst_n = 1'b0; tick(1); chk_state("R12 sync reset", S_OFF);
        chk_gates("R12 sync reset", 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_high();
        t_low_no_de();
        t_feedback();
        t_de_blank();
        t_zc_late();
        t_hold();
        t_hold_restart();
        t_de_mid();
        t_disable();
        t_supply();
        t_mid_reset();
        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule